// File: doc/BRIEF.md
# Manchester Serial Transmitter with Preamble Sequencer

This block turns a parallel data word into a Manchester-coded serial waveform. A producer offers a word with a valid/ready handshake. The block accepts it only while no frame is in flight. It then sends the word one bit at a time, least significant bit first. Each bit period has two halves, and the level always changes at the midpoint. An external half-bit strobe (`half_tick`) sets the pace: every strobe ends the current half-bit and starts the next one. The block does not generate this rate itself.

Before the data, the block can send a preamble of 0 to 15 bit periods. The preamble is built from one of four patterns: constant ones, constant zeros, alternating starting with zero, or alternating starting with one. Preamble bits use the same Manchester coding as data bits. A polarity control swaps the two halves of every symbol. The preamble length, pattern and polarity are captured when a word is accepted and hold until that frame ends. Between frames the line rests at a fixed idle level, and a busy flag marks the span of the frame.

Top module: `manch_tx`

## Requirements
- R1: With `cfg_pol` = 0, a data bit of value 1 is sent as high for the first half and low for the second half, and a 0 as low then high; data bits leave in LSB-first order.
- R2: With `cfg_pol` = 1, both halves of every symbol (preamble and data) are inverted compared with R1.
- R3: `cfg_pre_pat` selects the preamble bit values before polarity is applied: 0 = every bit 1, 1 = every bit 0, 2 = 0,1,0,1..., 3 = 1,0,1,0...; preamble bits are coded exactly like data bits.
- R4: `cfg_pre_len` = 0 sends no preamble, and the first data half-bit follows acceptance directly; values 1 to 15 send exactly that many preamble bit periods before the data.
- R5: The line changes only on a clock edge where `half_tick` is sampled high. The first half-bit of a frame is driven on the first such edge after the accepting edge; a strobe in the accepting cycle itself is ignored.
- R6: `in_ready` is high exactly when `busy` is low; a word offered while busy is not taken and does not disturb the frame in flight.
- R7: `busy` rises on the edge that accepts a word. It falls on the strobe edge that ends the final data half-bit, and on that same edge the line returns to `IDLE_LEVEL`. Whenever `busy` is low, the line sits at `IDLE_LEVEL`.
- R8: Preamble length, pattern and polarity are captured at acceptance; changing the configuration inputs during a frame has no effect on that frame.
- R9: After synchronous reset, the line is at `IDLE_LEVEL` (default 0), `busy` is 0 and `in_ready` is 1. The internally held configuration resets to length 4, pattern 0, polarity 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle strobe per half-bit period |
| cfg_pre_len | input | 4 | Preamble length in bit periods (0 = none) |
| cfg_pre_pat | input | 2 | Preamble pattern code |
| cfg_pol | input | 1 | Manchester polarity (1 = inverted) |
| in_valid | input | 1 | Data word offered |
| in_data | input | DATA_W | Data word, sent LSB first |
| in_ready | output | 1 | Block can accept a word |
| line_out | output | 1 | Manchester serial line |
| busy | output | 1 | Frame in progress |

## Verification
The hardest cases to reach from the ports are the ones where a configuration change or a second offered word arrives while a frame is mid-flight. The handshake, the configuration inputs and the half-bit strobe are all independent, so these events can land in the same cycle as acceptance or as the last strobe. The stimulus holds `in_valid` high across a whole frame. It changes length, pattern and polarity right after acceptance. It also runs with a strobe on every cycle, so acceptance and strobe coincide and the final strobe meets a pending word. A behavioural queue of expected half-bit levels is compared against the line, `busy` and `in_ready` on every clock.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

    localparam int LEN_W = 4;

    typedef enum logic [1:0] {
        PAT_ONES  = 2'd0,
        PAT_ZEROS = 2'd1,
        PAT_ZO    = 2'd2,
        PAT_OZ    = 2'd3
    } pre_pat_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        pre_pat_e         pat;
        logic             pol;
    } frame_cfg_t;

    localparam frame_cfg_t CFG_RESET = '{len: 4'd4, pat: PAT_ONES, pol: 1'b0};

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PRE  = 2'd1,
        SEQ_DATA = 2'd2,
        SEQ_STOP = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic vld;
        logic stop;
        logic bit_val;
        logic second;
    } emit_t;

    function automatic logic preamble_bit(pre_pat_e pat, logic odd);
        case (pat)
            PAT_ONES:  return 1'b1;
            PAT_ZEROS: return 1'b0;
            PAT_ZO:    return odd;
            default:   return ~odd;
        endcase
    endfunction

    function automatic logic half_level(logic b, logic pol, logic second);
        return (b ^ pol) ^ second;
    endfunction

endpackage

// File: rtl/mtx_preamble_gen.sv
module mtx_preamble_gen
    import mtx_pkg::*;
(
    input  pre_pat_e pat,
    input  logic     odd,
    output logic     pre_bit
);

    always_comb begin
        pre_bit = preamble_bit(pat, odd);
    end

endmodule

// File: rtl/mtx_sequencer.sv
module mtx_sequencer
    import mtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  frame_cfg_t        cfg_in,
    input  logic              pre_bit,
    output logic              pre_odd,
    output logic              in_ready,
    output logic              busy,
    output emit_t             emit,
    output frame_cfg_t        cfg_q
);

    localparam int DW_LOG = $clog2(DATA_W);
    localparam int CNT_W  = (DW_LOG > LEN_W) ? DW_LOG : LEN_W;
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  idx;
    logic              second;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  last_pre;

    assign last_pre = CNT_W'(cfg_q.len) - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            idx    <= '0;
            second <= 1'b0;
            shreg  <= '0;
            cfg_q  <= CFG_RESET;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (in_valid) begin
                        cfg_q  <= cfg_in;
                        shreg  <= in_data;
                        idx    <= '0;
                        second <= 1'b0;
                        state  <= (cfg_in.len != '0) ? SEQ_PRE : SEQ_DATA;
                    end
                end
                SEQ_PRE: begin
                    if (half_tick) begin
                        if (!second) begin
                            second <= 1'b1;
                        end else begin
                            second <= 1'b0;
                            if (idx == last_pre) begin
                                idx   <= '0;
                                state <= SEQ_DATA;
                            end else begin
                                idx <= idx + CNT_W'(1);
                            end
                        end
                    end
                end
                SEQ_DATA: begin
                    if (half_tick) begin
                        if (!second) begin
                            second <= 1'b1;
                        end else begin
                            second <= 1'b0;
                            shreg  <= shreg >> 1;
                            if (idx == LAST_DATA) begin
                                idx   <= '0;
                                state <= SEQ_STOP;
                            end else begin
                                idx <= idx + CNT_W'(1);
                            end
                        end
                    end
                end
                default: begin
                    if (half_tick) begin
                        state <= SEQ_IDLE;
                    end
                end
            endcase
        end
    end

    always_comb begin
        in_ready     = (state == SEQ_IDLE);
        busy         = (state != SEQ_IDLE);
        pre_odd      = idx[0];
        emit.vld     = half_tick && ((state == SEQ_PRE) || (state == SEQ_DATA));
        emit.stop    = half_tick && (state == SEQ_STOP);
        emit.bit_val = (state == SEQ_PRE) ? pre_bit : shreg[0];
        emit.second  = second;
    end

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !$past(rst) && $past(busy) |-> $stable(cfg_q));

    // R6
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> busy);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !half_tick && !(in_valid && in_ready) |=> $stable(busy));

endmodule

// File: rtl/mtx_encoder.sv
module mtx_encoder
    import mtx_pkg::*;
#(
    parameter bit IDLE_LEVEL = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  emit_t emit,
    input  logic  pol,
    output logic  line
);

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= IDLE_LEVEL;
        end else if (emit.vld) begin
            line <= half_level(emit.bit_val, pol, emit.second);
        end else if (emit.stop) begin
            line <= IDLE_LEVEL;
        end
    end

    // R1
    mid_flip_chk: assert property (@(posedge clk) disable iff (rst)
        emit.vld && emit.second |=> line != $past(line));

    // R5
    line_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(emit.vld) && !$past(emit.stop) |-> $stable(line));

endmodule

// File: rtl/manch_tx.sv
module manch_tx
    import mtx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter bit IDLE_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic [3:0]        cfg_pre_len,
    input  logic [1:0]        cfg_pre_pat,
    input  logic              cfg_pol,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              line_out,
    output logic              busy
);

    frame_cfg_t cfg_in;
    frame_cfg_t cfg_q;
    emit_t      emit;
    logic       pre_bit;
    logic       pre_odd;

    always_comb begin
        cfg_in.len = cfg_pre_len;
        cfg_in.pat = pre_pat_e'(cfg_pre_pat);
        cfg_in.pol = cfg_pol;
    end

    mtx_preamble_gen i_pre (
        .pat     (cfg_q.pat),
        .odd     (pre_odd),
        .pre_bit (pre_bit)
    );

    mtx_sequencer #(.DATA_W(DATA_W)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .half_tick (half_tick),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .cfg_in    (cfg_in),
        .pre_bit   (pre_bit),
        .pre_odd   (pre_odd),
        .in_ready  (in_ready),
        .busy      (busy),
        .emit      (emit),
        .cfg_q     (cfg_q)
    );

    mtx_encoder #(.IDLE_LEVEL(IDLE_LEVEL)) i_enc (
        .clk  (clk),
        .rst  (rst),
        .emit (emit),
        .pol  (cfg_q.pol),
        .line (line_out)
    );

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> line_out == IDLE_LEVEL);

    // R6
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready != busy);

endmodule

// File: tb/test_manch_tx.sv
module test_manch_tx;

    localparam int DATA_W = 8;
    localparam bit IDLE   = 1'b0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              half_tick = 1'b0;
    logic [3:0]        cfg_pre_len = 4'd0;
    logic [1:0]        cfg_pre_pat = 2'd0;
    logic              cfg_pol = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ready;
    logic              line_out;
    logic              busy;

    manch_tx #(.DATA_W(DATA_W), .IDLE_LEVEL(IDLE)) i_manch_tx (
        .clk         (clk),
        .rst         (rst),
        .half_tick   (half_tick),
        .cfg_pre_len (cfg_pre_len),
        .cfg_pre_pat (cfg_pre_pat),
        .cfg_pol     (cfg_pol),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .line_out    (line_out),
        .busy        (busy)
    );

    always #10 clk = ~clk;

    typedef struct {
        bit    level;
        string tag;
    } half_t;

    half_t q[$];
    bit    m_busy = 1'b0;
    bit    m_line = IDLE;
    string m_tag  = "R7";
    string scen   = "reset";
    int    checks = 0;
    int    errors = 0;
    int    tick_div = 3;
    int    tick_cnt = 0;
    bit    done = 1'b0;

    function automatic bit pat_bit(int pat, int k);
        case (pat)
            0: return 1'b1;
            1: return 1'b0;
            2: return (k % 2) == 1;
            default: return (k % 2) == 0;
        endcase
    endfunction

    // Reference model: queue of expected half-bit levels
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_busy = 1'b0;
            m_line = IDLE;
            m_tag  = "R9";
        end else if (in_valid && !m_busy) begin
            bit p;
            p = cfg_pol;
            for (int k = 0; k < int'(cfg_pre_len); k++) begin
                bit b;
                b = pat_bit(int'(cfg_pre_pat), k) ^ p;
                q.push_back('{b, "R3 R4 R5"});
                q.push_back('{~b, "R3 R4 R5"});
            end
            for (int i = 0; i < DATA_W; i++) begin
                bit b;
                b = in_data[i] ^ p;
                q.push_back('{b, p ? "R2 R5" : "R1 R5"});
                q.push_back('{~b, p ? "R2 R5" : "R1 R5"});
            end
            q.push_back('{IDLE, "R7"});
            m_busy = 1'b1;
        end else if (half_tick && m_busy) begin
            half_t e;
            e = q.pop_front();
            m_line = e.level;
            m_tag  = e.tag;
            if (q.size() == 0) m_busy = 1'b0;
        end
    end

    task automatic chk(input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] act=%0b exp=%0b t=%0t", what, scen, act, exp, $time);
        end
    endtask

    // Compare and drive the strobe away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(line_out, m_line, {m_tag, " line"});
            chk(busy, m_busy, "R7 busy");
            chk(in_ready, !m_busy, "R6 ready");
        end
        tick_cnt++;
        half_tick <= (tick_cnt % tick_div) == 0;
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [DATA_W-1:0] d, input int len, input int pat,
                        input bit pol, input string s);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        scen        = s;
        cfg_pre_len = 4'(len);
        cfg_pre_pat = 2'(pat);
        cfg_pol     = pol;
        in_data     = d;
        in_valid    = 1'b1;
        @(negedge clk);
        in_valid    = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(line_out, IDLE, "R9 line");
        chk(busy, 1'b0, "R9 busy");
        chk(in_ready, 1'b1, "R9 ready");

        send(8'hA5, 4, 0, 1'b0, "R1 default preamble");   wait_idle();
        send(8'h3C, 3, 1, 1'b0, "R3 zeros");              wait_idle();
        send(8'hF0, 5, 2, 1'b0, "R3 alt from zero");      wait_idle();
        send(8'h0F, 5, 3, 1'b0, "R3 alt from one");       wait_idle();
        send(8'h81, 0, 3, 1'b0, "R4 no preamble");        wait_idle();
        send(8'h5A, 15, 2, 1'b1, "R2 R4 max length inv"); wait_idle();
        send(8'hC3, 1, 0, 1'b1, "R2 inverted ones");      wait_idle();

        // R8: configuration changes right after acceptance
        send(8'h96, 2, 3, 1'b0, "R8 cfg change");
        cfg_pre_len = 4'd9; cfg_pre_pat = 2'd1; cfg_pol = 1'b1;
        wait_idle();

        // R6: word held valid across a frame; R5 strobe every cycle
        tick_div = 1;
        send(8'h6E, 2, 2, 1'b1, "R6 R5 held valid");
        in_valid = 1'b1; in_data = 8'h11;
        repeat (20) @(negedge clk);
        chk(busy, 1'b1, "R6 still busy");
        while (busy) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        wait_idle();

        tick_div = 2;
        send(8'hFF, 0, 0, 1'b0, "R4 R1 all ones");        wait_idle();
        send(8'h00, 7, 1, 1'b1, "R2 all zeros");          wait_idle();

        // R9 reset mid-frame
        send(8'hAA, 6, 0, 1'b0, "R9 reset midframe");
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(line_out, IDLE, "R9 line after reset");
        chk(busy, 1'b0, "R9 busy after reset");
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule